// File: doc/BRIEF.md
# Clamp and Horizontal Sync Pulse Generator

This block runs in the pixel-clock domain of a video front end. It takes a raw horizontal sync line and turns it into two timing pulses. The first is a clamp pulse that opens a set number of pixel clocks after the trailing edge of the sync and stays open for a set number of clocks. The second is a regenerated horizontal sync of set width and selectable output polarity. The sync line may arrive active-high or active-low. Its polarity comes either from a detector outside this block or from a configuration bit. All timing is measured on the sync after it has been normalized to active-high.

A source selector can replace the internally timed clamp with an external clamp line. That line has its own polarity setting. Both asynchronous inputs pass through flop synchronizers before they are used. All configuration arrives as static fields and should only change while the block is held in reset. After reset the recommended field values are 8 for clamp delay, 20 for clamp width and 32 for sync width.

Top module: `clamp_sync_gen`

## Requirements
- R1: Let a normalized leading edge of `hsync_raw_i` first be sampled at rising edge k. The sync pulse is then active from edge k+2 onward. A new leading edge during a pulse restarts the pulse.
- R2: The sync pulse stays active for exactly `cfg_hsout_width_i` clocks. A width of 0 produces no pulse.
- R3: `hsout_o` is high while the pulse is active when `cfg_hsout_pol_i`=0, and low while it is active when `cfg_hsout_pol_i`=1. When the pulse is inactive, `hsout_o` equals `cfg_hsout_pol_i`.
- R4: When `cfg_hs_pol_ovr_i`=0, the input polarity is taken from `hs_pol_detect_i`. When it is 1, the polarity is taken from `cfg_hs_pol_i`. In both cases a value of 1 means active-high and 0 means active-low.
- R5: Let a normalized trailing edge first be sampled at edge k, and let the clamp source be internal (`cfg_clamp_src_i`=0). The clamp is then active from edge k+2+D onward, where D is `cfg_clamp_delay_i` and D=0 is allowed.
- R6: The internal clamp stays active for exactly `cfg_clamp_width_i` clocks. A width of 0 produces no clamp.
- R7: A trailing edge that arrives while a clamp is waiting out its delay, or is active, cancels that clamp and restarts the delay from the new edge.
- R8: When `cfg_clamp_src_i`=1, the value of `clamp_o` after edge k is the external clamp sampled at edge k-1. It is inverted when `cfg_clamp_ext_pol_i`=1, where 0 means active-high and 1 means active-low. Sync activity has no effect on `clamp_o` in this mode.
- R9: During reset the sync pulse and the internal clamp are inactive. No sync edge is recognized until three clock edges after reset have filled the synchronizer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hsync_raw_i | input | 1 | Raw horizontal sync, asynchronous |
| clamp_ext_i | input | 1 | External clamp, asynchronous |
| hs_pol_detect_i | input | 1 | Detected sync polarity, 1 = active-high |
| cfg_hs_pol_ovr_i | input | 1 | Use the configured sync polarity instead of the detected one |
| cfg_hs_pol_i | input | 1 | Configured sync polarity, 1 = active-high |
| cfg_hsout_pol_i | input | 1 | Output sync polarity, 0 = active-high |
| cfg_clamp_src_i | input | 1 | Clamp source, 0 = internal timing, 1 = external |
| cfg_clamp_ext_pol_i | input | 1 | External clamp polarity, 0 = active-high |
| cfg_clamp_delay_i | input | 8 | Clocks from sync trailing edge to clamp start |
| cfg_clamp_width_i | input | 8 | Clamp length in clocks |
| cfg_hsout_width_i | input | 8 | Regenerated sync length in clocks |
| clamp_o | output | 1 | Clamp pulse, active-high |
| hsout_o | output | 1 | Regenerated horizontal sync |

## Verification
The hardest situations to reach are the restart cases. In these, a second trailing edge lands inside the delay window or inside an active clamp, or a second leading edge lands inside a long sync pulse. The stimulus reaches them with short sync periods, in which the gap between pulses is smaller than the programmed delay or width. The first-cycles case is also hard: it only shows up when the sync input is held at its active level through reset and released afterwards, which the first scenario does. A behavioural model of edge times in the bench predicts both outputs on every clock.

// File: rtl/csg_pkg.sv
package csg_pkg;
   localparam int CSG_CNT_W_DEF       = 8;
   localparam int CSG_SYNC_STAGES_DEF = 2;
   // recommended field values after reset
   localparam int CSG_CLAMP_DELAY_RST = 8;
   localparam int CSG_CLAMP_WIDTH_RST = 20;
   localparam int CSG_HSOUT_WIDTH_RST = 32;

   // effective input polarity: 1 = active-high
   function automatic logic csg_eff_pol(input logic ovr, input logic cfg_pol, input logic det_pol);
      return ovr ? cfg_pol : det_pol;
   endfunction
endpackage

// File: rtl/csg_sync.sv
module csg_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_i,
   output logic q_o
);
   if (STAGES < 2) begin : g_bad_stages
      $error("csg_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain_q;

   always_ff @(posedge clk) begin
      if (!rst_n) chain_q <= '0;
      else        chain_q <= {chain_q[STAGES-2:0], d_i};
   end

   assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/csg_edge_det.sv
module csg_edge_det #(
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic raw_i,
   input  logic pol_high_i,
   output logic lead_o,
   output logic trail_o
);
   localparam int FILL = SYNC_STAGES + 1;
   localparam int FW   = $clog2(FILL + 1);

   logic          sync_s;
   logic          prev_q;
   logic [FW-1:0] fill_q;
   logic          primed;
   logic          norm_now, norm_prev;

   csg_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .d_i  (raw_i),
      .q_o  (sync_s)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         prev_q <= 1'b0;
         fill_q <= '0;
      end else begin
         prev_q <= sync_s;
         if (!primed) fill_q <= fill_q + 1'b1;
      end
   end

   assign primed    = (fill_q == FW'(FILL));
   assign norm_now  = pol_high_i ? sync_s : ~sync_s;
   assign norm_prev = pol_high_i ? prev_q : ~prev_q;
   assign lead_o    = primed &  norm_now & ~norm_prev;
   assign trail_o   = primed & ~norm_now &  norm_prev;
endmodule

// File: rtl/csg_delay_pulse.sv
module csg_delay_pulse #(
   parameter int CNT_W    = 8,
   parameter bit DELAY_EN = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_i,
   input  logic [CNT_W-1:0] delay_i,
   input  logic [CNT_W-1:0] width_i,
   output logic             active_o,
   output logic             pend_o
);
   logic [CNT_W-1:0] wcnt_q;
   logic             fire;
   logic             kill;

   if (DELAY_EN) begin : g_delay
      logic [CNT_W-1:0] dcnt_q;
      logic             pend_q;

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            dcnt_q <= '0;
            pend_q <= 1'b0;
         end else if (start_i) begin
            dcnt_q <= delay_i;
            pend_q <= (delay_i != '0);
         end else if (pend_q) begin
            dcnt_q <= dcnt_q - 1'b1;
            if (dcnt_q == CNT_W'(1)) pend_q <= 1'b0;
         end
      end

      assign fire   = (start_i && delay_i == '0) || (!start_i && pend_q && dcnt_q == CNT_W'(1));
      assign kill   = start_i && delay_i != '0;
      assign pend_o = pend_q;
   end else begin : g_nodelay
      logic unused_delay;
      assign unused_delay = ^delay_i;
      assign fire   = start_i;
      assign kill   = 1'b0;
      assign pend_o = 1'b0;
   end

   always_ff @(posedge clk) begin
      if (!rst_n)              wcnt_q <= '0;
      else if (fire)           wcnt_q <= width_i;
      else if (kill)           wcnt_q <= '0;
      else if (wcnt_q != '0)   wcnt_q <= wcnt_q - 1'b1;
   end

   assign active_o = (wcnt_q != '0);
endmodule

// File: rtl/clamp_sync_gen.sv
module clamp_sync_gen
   import csg_pkg::*;
#(
   parameter int CNT_W       = CSG_CNT_W_DEF,
   parameter int SYNC_STAGES = CSG_SYNC_STAGES_DEF
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             hsync_raw_i,
   input  logic             clamp_ext_i,
   input  logic             hs_pol_detect_i,
   input  logic             cfg_hs_pol_ovr_i,
   input  logic             cfg_hs_pol_i,
   input  logic             cfg_hsout_pol_i,
   input  logic             cfg_clamp_src_i,
   input  logic             cfg_clamp_ext_pol_i,
   input  logic [CNT_W-1:0] cfg_clamp_delay_i,
   input  logic [CNT_W-1:0] cfg_clamp_width_i,
   input  logic [CNT_W-1:0] cfg_hsout_width_i,
   output logic             clamp_o,
   output logic             hsout_o
);
   if (CNT_W < 2 || CNT_W > 16) begin : g_bad_cnt
      $error("clamp_sync_gen: CNT_W out of range");
   end

   logic pol_high;
   logic lead_evt, trail_evt;
   logic hs_active, hs_pend_unused;
   logic clamp_int, clamp_pend;
   logic ext_s, ext_act;
   logic [CNT_W-1:0] zero_delay;

   assign pol_high   = csg_eff_pol(cfg_hs_pol_ovr_i, cfg_hs_pol_i, hs_pol_detect_i);
   assign zero_delay = '0;

   csg_edge_det #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
      .clk       (clk),
      .rst_n     (rst_n),
      .raw_i     (hsync_raw_i),
      .pol_high_i(pol_high),
      .lead_o    (lead_evt),
      .trail_o   (trail_evt)
   );

   csg_delay_pulse #(.CNT_W(CNT_W), .DELAY_EN(1'b0)) u_hs_pulse (
      .clk     (clk),
      .rst_n   (rst_n),
      .start_i (lead_evt),
      .delay_i (zero_delay),
      .width_i (cfg_hsout_width_i),
      .active_o(hs_active),
      .pend_o  (hs_pend_unused)
   );

   csg_delay_pulse #(.CNT_W(CNT_W), .DELAY_EN(1'b1)) u_clamp_pulse (
      .clk     (clk),
      .rst_n   (rst_n),
      .start_i (trail_evt),
      .delay_i (cfg_clamp_delay_i),
      .width_i (cfg_clamp_width_i),
      .active_o(clamp_int),
      .pend_o  (clamp_pend)
   );

   csg_sync #(.STAGES(SYNC_STAGES)) u_ext_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .d_i  (clamp_ext_i),
      .q_o  (ext_s)
   );

   assign ext_act = ext_s ^ cfg_clamp_ext_pol_i;
   assign clamp_o = cfg_clamp_src_i ? ext_act : clamp_int;
   assign hsout_o = hs_active ^ cfg_hsout_pol_i;
endmodule

// File: rtl/clamp_sync_chk.sv
module clamp_sync_chk #(
   parameter int CNT_W = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic             clamp_ext_i,
   input logic             cfg_hsout_pol_i,
   input logic             cfg_clamp_src_i,
   input logic             cfg_clamp_ext_pol_i,
   input logic [CNT_W-1:0] cfg_clamp_delay_i,
   input logic [CNT_W-1:0] cfg_clamp_width_i,
   input logic [CNT_W-1:0] cfg_hsout_width_i,
   input logic             clamp_o,
   input logic             hsout_o,
   input logic             lead_evt,
   input logic             clamp_pend
);
   logic [1:0] age_q;

   always_ff @(posedge clk) begin
      if (!rst_n)              age_q <= '0;
      else if (age_q != 2'd2)  age_q <= age_q + 1'b1;
   end

   p_hs_start_r1: assert property (@(posedge clk) disable iff (!rst_n)
      ((hsout_o ^ cfg_hsout_pol_i) && !$past(hsout_o ^ cfg_hsout_pol_i)) |-> $past(lead_evt));

   p_hs_zero_width_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_hsout_width_i == '0) |-> (hsout_o == cfg_hsout_pol_i));

   p_clamp_after_delay_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (!cfg_clamp_src_i && cfg_clamp_delay_i != '0 && $rose(clamp_o)) |-> $past(clamp_pend));

   p_clamp_zero_width_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (!cfg_clamp_src_i && cfg_clamp_width_i == '0) |-> !clamp_o);

   p_ext_clamp_path_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_clamp_src_i && age_q == 2'd2) |-> (clamp_o == ($past(clamp_ext_i, 2) ^ cfg_clamp_ext_pol_i)));
endmodule

bind clamp_sync_gen clamp_sync_chk #(.CNT_W(CNT_W)) chk_i (
   .clk                (clk),
   .rst_n              (rst_n),
   .clamp_ext_i        (clamp_ext_i),
   .cfg_hsout_pol_i    (cfg_hsout_pol_i),
   .cfg_clamp_src_i    (cfg_clamp_src_i),
   .cfg_clamp_ext_pol_i(cfg_clamp_ext_pol_i),
   .cfg_clamp_delay_i  (cfg_clamp_delay_i),
   .cfg_clamp_width_i  (cfg_clamp_width_i),
   .cfg_hsout_width_i  (cfg_hsout_width_i),
   .clamp_o            (clamp_o),
   .hsout_o            (hsout_o),
   .lead_evt           (lead_evt),
   .clamp_pend         (clamp_pend)
);

// File: tb/clamp_sync_gen_tb_top.sv
module clamp_sync_gen_tb_top;
   logic clk = 1'b0;
   always #10 clk = ~clk;

   logic       rst_n = 1'b0;
   logic       hs_raw = 1'b0, ext = 1'b0, det = 1'b1;
   logic       c_ovr = 1'b1, c_pol = 1'b1, c_opol = 1'b0, c_src = 1'b0, c_epol = 1'b0;
   logic [7:0] c_cd = 8'd8, c_cw = 8'd20, c_hw = 8'd32;
   logic       clamp_o, hsout_o;

   clamp_sync_gen dut_i (
      .clk(clk), .rst_n(rst_n), .hsync_raw_i(hs_raw), .clamp_ext_i(ext),
      .hs_pol_detect_i(det), .cfg_hs_pol_ovr_i(c_ovr), .cfg_hs_pol_i(c_pol),
      .cfg_hsout_pol_i(c_opol), .cfg_clamp_src_i(c_src), .cfg_clamp_ext_pol_i(c_epol),
      .cfg_clamp_delay_i(c_cd), .cfg_clamp_width_i(c_cw), .cfg_hsout_width_i(c_hw),
      .clamp_o(clamp_o), .hsout_o(hsout_o)
   );

   int    e = 0;
   bit    hq[$];
   bit    xq[$];
   int    t_tr = -100000, t_ld = -100000;
   int    nchk = 0, nerr = 0;
   string tag = "R9";
   bit    done = 1'b0;

   function automatic bit act_lvl();
      bit ph;
      ph = c_ovr ? c_pol : det;   // R4
      return ph;
   endfunction

   function automatic bit nrm(bit v);
      return act_lvl() ? v : ~v;
   endfunction

   // behavioural model: record samples and edge times
   always @(posedge clk) begin
      if (rst_n) begin
         bit a, b;
         e++;
         hq.push_back(hs_raw);
         xq.push_back(ext);
         if (e >= 4) begin
            a = nrm(hq[e-3]);
            b = nrm(hq[e-4]);
            if (b && !a) t_tr = e;
            if (!b && a) t_ld = e;
         end
      end
   end

   task automatic check(string what, logic act, logic exp);
      nchk++;
      if (act !== exp) begin
         nerr++;
         $display("FAIL %s %s at cycle %0d: got %b expected %b", tag, what, e, act, exp);
      end
   endtask

   always @(negedge clk) begin
      if (!done) begin
         if (!rst_n) begin
            // R9 reset state
            check("R9 hsout_o in reset", hsout_o, c_opol);
            check("R9 clamp_o in reset", clamp_o, c_src ? c_epol : 1'b0);
         end else if (e >= 1) begin
            bit cl_int, hs_act, s2;
            cl_int = (e >= t_tr + int'(c_cd)) && (e < t_tr + int'(c_cd) + int'(c_cw));
            hs_act = (e >= t_ld) && (e < t_ld + int'(c_hw));
            s2     = (e >= 2) ? xq[e-2] : 1'b0;
            check("hsout_o", hsout_o, hs_act ^ c_opol);
            check("clamp_o", clamp_o, c_src ? (s2 ^ c_epol) : cl_int);
         end
      end
   end

   task automatic do_reset(bit idle);
      rst_n = 1'b0;
      hs_raw = idle;
      repeat (3) @(negedge clk);
      e = 0; hq.delete(); xq.delete();
      t_tr = -100000; t_ld = -100000;
      rst_n = 1'b1;
   endtask

   task automatic pulse(int a, int g);
      bit l;
      l = act_lvl();
      hs_raw = l;
      repeat (a) @(negedge clk);
      hs_raw = ~l;
      repeat (g) @(negedge clk);
   endtask

   task automatic summary();
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         nchk++; nerr++;
         $display("FAIL watchdog expired: got hang expected completion");
         summary();
         $finish;
      end
   end

   initial begin
      @(negedge clk);
      // S1: recommended values, active-high by override, input held active across reset (R9)
      tag = "R1 R2 R5 R6 R9";
      c_ovr = 1; c_pol = 1; det = 0; c_opol = 0; c_src = 0;
      c_cd = 8'd8; c_cw = 8'd20; c_hw = 8'd32;
      do_reset(1'b1);
      repeat (12) @(negedge clk);
      hs_raw = 1'b0; repeat (80) @(negedge clk);
      for (int i = 0; i < 3; i++) pulse(10, 80);

      // S2: polarity from detector (active-low), inverted output, zero delay
      tag = "R3 R4 R5";
      c_ovr = 0; det = 0; c_opol = 1; c_cd = 8'd0; c_cw = 8'd3; c_hw = 8'd5;
      do_reset(1'b1);
      for (int i = 0; i < 4; i++) pulse(7 + i, 25);

      // S3: override beats detector (active-low configured, detector says high)
      tag = "R4 R5 R6";
      c_ovr = 1; c_pol = 0; det = 1; c_opol = 0; c_cd = 8'd3; c_cw = 8'd6; c_hw = 8'd9;
      do_reset(1'b1);
      for (int i = 0; i < 4; i++) pulse(5, 30);

      // S4: trailing edges inside delay window
      tag = "R7 delay restart";
      c_ovr = 1; c_pol = 1; c_cd = 8'd30; c_cw = 8'd10; c_hw = 8'd3;
      do_reset(1'b0);
      for (int i = 0; i < 5; i++) pulse(4, 10);
      repeat (60) @(negedge clk);

      // S5: trailing edges inside active clamp
      tag = "R7 active restart";
      c_cd = 8'd2; c_cw = 8'd40;
      do_reset(1'b0);
      for (int i = 0; i < 5; i++) pulse(3, 20);
      repeat (60) @(negedge clk);

      // S6: zero widths produce no pulses
      tag = "R2 R6 zero width";
      c_cd = 8'd4; c_cw = 8'd0; c_hw = 8'd0; c_opol = 1;
      do_reset(1'b0);
      for (int i = 0; i < 4; i++) pulse(6, 20);

      // S7: sync pulse restarted by a new leading edge, widest counts
      tag = "R1 R2 retrigger";
      c_opol = 0; c_hw = 8'd60; c_cd = 8'd255; c_cw = 8'd255;
      do_reset(1'b0);
      for (int i = 0; i < 4; i++) pulse(5, 35);
      repeat (600) @(negedge clk);

      // S8/S9: external clamp, both polarities, sync activity ignored
      for (int p = 0; p < 2; p++) begin
         tag = "R8 external clamp";
         c_src = 1; c_epol = p[0]; c_cd = 8'd1; c_cw = 8'd5; c_hw = 8'd4;
         do_reset(1'b0);
         for (int i = 0; i < 80; i++) begin
            ext = $urandom_range(0, 1);
            hs_raw = ((i % 9) < 3);
            @(negedge clk);
         end
      end

      done = 1'b1;
      summary();
      $finish;
   end
endmodule